// File: doc/BRIEF.md
# Two-Read One-Write Register Bank

This block holds fifteen 64-bit words addressed by 4-bit selectors. Two read ports are independent. Each one returns the word named by its selector as pure combinational logic. A single write port stores a word when the clock rises. The all-ones selector value (15) names no register. On a read port it yields zero, and on the write port it suppresses the store. The write port therefore needs no separate enable.

The block is meant for a processor datapath that fetches two operands and retires one result per cycle. A read that names the register being written in the same cycle sees the old contents until the edge, and the new contents after it. Any forwarding must sit outside the bank. An active-low synchronous reset zeroes every register.

Top module: `dual_port_regbank`

## Requirements
- R1: While rst_n is low at a rising clock edge, all fifteen registers become zero, and a pending write in that cycle is discarded.
- R2: rd_a_data shows the contents of the register named by rd_a_sel (0 to 14) combinationally, with no clock edge required.
- R3: rd_b_data works like rd_a_data but is driven by rd_b_sel, independently of port A.
- R4: When wr_sel is 0 to 14 at a rising edge with rst_n high, that register takes wr_data, and the other registers keep their values.
- R5: When wr_sel is 15 (all ones) at a rising edge, no register changes.
- R6: A read selector equal to 15 drives all 64 output bits to zero.
- R7: A read of the register being written in the same cycle returns the previous value before the edge, and wr_data after it. There is no internal bypass.
- R8: Both reads and one write may be issued in the same cycle without affecting one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low clear of all registers |
| rd_a_sel | input | 4 | Read port A selector; 15 = none |
| rd_a_data | output | 64 | Read port A data |
| rd_b_sel | input | 4 | Read port B selector; 15 = none |
| rd_b_data | output | 64 | Read port B data |
| wr_sel | input | 4 | Write selector; 15 = no write |
| wr_data | input | 64 | Word to store |

## Verification
The assertions check four behaviours on every cycle:
- The null selector reads as zero on both ports.
- A stored word is visible one edge after its write whenever a port names that register.
- A null write leaves a port's data unchanged while its selector is held.
- Both ports read zero right after a reset edge.

Only the bench's scenarios can show three further behaviours:
- The pre-edge old value during a same-cycle read and write of one register.
- That every one of the fifteen registers keeps its own contents.
- That reset overrides a write issued in the same cycle.

// File: rtl/regbank_pkg.sv
// Shared sizing for the register bank.
// Assumes the selector is at least 2 bits wide and that the all-ones code is reserved.
package regbank_pkg;
    localparam int RB_SEL_W  = 4;
    localparam int RB_DATA_W = 64;

    // Number of real registers: every code except the all-ones one
    function automatic int reg_count(input int sel_w);
        return (1 << sel_w) - 1;
    endfunction
endpackage

// File: rtl/regbank_wr_decode.sv
// Turns the write selector into a one-hot vector of per-register enables.
// Assumes NUM_REGS excludes the null code, so a null selector enables nothing.
module regbank_wr_decode #(
    parameter int SEL_W    = 4,
    parameter int NUM_REGS = 15
) (
    input  logic [SEL_W-1:0]    wr_sel,
    output logic [NUM_REGS-1:0] wr_en
);
    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_dec
            // One comparator for each register index
            assign wr_en[g] = (wr_sel == SEL_W'(g));
        end
    endgenerate
endmodule

// File: rtl/regbank_storage.sv
// Array of edge-triggered words with a synchronous active-low clear.
// Assumes at most one wr_en bit is high; reset wins over a write.
module regbank_storage #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 15
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_REGS-1:0]              wr_en,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_word
            // Clear on reset, otherwise load when this word is enabled
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[g] <= '0;
                else if (wr_en[g])
                    regs_q[g] <= wr_data;
            end
        end
    endgenerate
endmodule

// File: rtl/regbank_read_port.sv
// Combinational read mux; a selector beyond the last register gives zero.
// Assumes the null code is numerically larger than every register index.
module regbank_read_port #(
    parameter int SEL_W    = 4,
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 15
) (
    input  logic [SEL_W-1:0]                 rd_sel,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
    output logic [DATA_W-1:0]                rd_data
);
    // Select the matching word; no match leaves zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_sel == SEL_W'(i))
                rd_data = regs_q[i];
        end
    end
endmodule

// File: rtl/dual_port_regbank.sv
// Top of the register bank: two combinational reads and one clocked write.
// Assumes the all-ones selector means "no register" on every port.
module dual_port_regbank #(
    parameter int SEL_W  = regbank_pkg::RB_SEL_W,
    parameter int DATA_W = regbank_pkg::RB_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int NUM_REGS = regbank_pkg::reg_count(SEL_W);

    logic [NUM_REGS-1:0]             wr_en;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    regbank_wr_decode #(.SEL_W(SEL_W), .NUM_REGS(NUM_REGS)) u_dec (
        .wr_sel (wr_sel),
        .wr_en  (wr_en)
    );

    regbank_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    regbank_read_port #(.SEL_W(SEL_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_a (
        .rd_sel  (rd_a_sel),
        .regs_q  (regs_q),
        .rd_data (rd_a_data)
    );

    regbank_read_port #(.SEL_W(SEL_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_b (
        .rd_sel  (rd_b_sel),
        .regs_q  (regs_q),
        .rd_data (rd_b_data)
    );
endmodule

// File: rtl/regbank_checker.sv
// Port-level properties of the register bank, attached to every instance by bind.
// Assumes the null selector is the all-ones code.
module regbank_checker #(
    parameter int SEL_W  = 4,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  rd_a_sel,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [SEL_W-1:0]  rd_b_sel,
    input logic [DATA_W-1:0] rd_b_data,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DATA_W-1:0] wr_data
);
    localparam logic [SEL_W-1:0] NULL_ID = {SEL_W{1'b1}};

    logic rst_seen;
    // Marks the cycle right after a reset edge
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R6: the null selector reads zero
    a_r6_null_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_a_sel == NULL_ID) -> (rd_a_data == '0)) &&
        ((rd_b_sel == NULL_ID) -> (rd_b_data == '0)));

    // R1: both ports read zero after a reset edge
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen |-> (rd_a_data == '0 && rd_b_data == '0));

    // R4 / R2 / R3: a written word is visible one edge later
    a_r4_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel != NULL_ID) |=>
        ((rd_a_sel != $past(wr_sel) || rd_a_data == $past(wr_data)) &&
         (rd_b_sel != $past(wr_sel) || rd_b_data == $past(wr_data))));

    // R5: a null write leaves the read data unchanged while the selector is held
    a_r5_null_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == NULL_ID) |=>
        (($stable(rd_a_sel) -> $stable(rd_a_data)) &&
         ($stable(rd_b_sel) -> $stable(rd_b_data))));
endmodule

bind dual_port_regbank regbank_checker #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_sel  (rd_a_sel),
    .rd_a_data (rd_a_data),
    .rd_b_sel  (rd_b_sel),
    .rd_b_data (rd_b_data),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data)
);

// File: tb/dual_port_regbank_test.sv
module dual_port_regbank_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 4 + 64 + 4 + 4 + 64 + 64;
    localparam int NROWS = 8;

    // Row: write sel, write data, read A sel, read B sel, expected A, expected B (pre-edge)
    localparam logic [ROW_W-1:0] VEC [NROWS] = '{
        {4'd3,  64'h0000_0000_0000_1111, 4'd3,  4'd15, 64'h0, 64'h0},
        {4'd5,  64'hA5A5_A5A5_A5A5_A5A5, 4'd3,  4'd5,  64'h0000_0000_0000_1111, 64'h0},
        {4'd15, 64'hDEAD_BEEF_DEAD_BEEF, 4'd5,  4'd15, 64'hA5A5_A5A5_A5A5_A5A5, 64'h0},
        {4'd0,  64'hFFFF_FFFF_FFFF_FFFF, 4'd3,  4'd14, 64'h0000_0000_0000_1111, 64'h0},
        {4'd14, 64'h0123_4567_89AB_CDEF, 4'd0,  4'd5,  64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_A5A5_A5A5_A5A5},
        {4'd3,  64'h0000_0000_0000_2222, 4'd14, 4'd3,  64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_1111},
        {4'd15, 64'h0,                   4'd3,  4'd14, 64'h0000_0000_0000_2222, 64'h0123_4567_89AB_CDEF},
        {4'd15, 64'h0,                   4'd15, 4'd0,  64'h0, 64'hFFFF_FFFF_FFFF_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_sel = 4'd15;
    logic [3:0]  rd_b_sel = 4'd15;
    logic [3:0]  wr_sel = 4'd15;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_a_data, rd_b_data;
    logic [63:0] model [15];
    int errors = 0;
    int checks = 0;

    dual_port_regbank uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .wr_sel(wr_sel), .wr_data(wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read every register through both ports with no write pending
    task automatic sweep(input string req);
        wr_sel = 4'd15;
        for (int i = 0; i < 15; i++) begin
            rd_a_sel = 4'(i);
            rd_b_sel = 4'(14 - i);
            #1;
            check(req, rd_a_data, model[i]);
            check(req, rd_b_data, model[14 - i]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 15; i++) model[i] = '0;
        // Reset with a write pending: the write must be dropped (R1)
        wr_sel = 4'd2;
        wr_data = 64'h5555_5555_5555_5555;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wr_sel = 4'd15;
        sweep("R1 reset state");

        // Table walk: reads checked just before the write edge (R2 R3 R4 R5 R6 R7 R8)
        for (int r = 0; r < NROWS; r++) begin
            @(negedge clk);
            {wr_sel, wr_data, rd_a_sel, rd_b_sel} = VEC[r][ROW_W-1:128];
            #1;
            check("R2/R6/R7 table port A", rd_a_data, VEC[r][127:64]);
            check("R3/R6/R8 table port B", rd_b_data, VEC[r][63:0]);
        end
        @(negedge clk);
        model[0]  = 64'hFFFF_FFFF_FFFF_FFFF;
        model[3]  = 64'h0000_0000_0000_2222;
        model[5]  = 64'hA5A5_A5A5_A5A5_A5A5;
        model[14] = 64'h0123_4567_89AB_CDEF;
        sweep("R4/R5 contents after writes");

        // R7: the new value appears after the edge
        @(negedge clk);
        wr_sel = 4'd9; wr_data = 64'hCAFE_0000_0000_0009;
        rd_a_sel = 4'd9; rd_b_sel = 4'd9;
        #1;
        check("R7 before edge", rd_a_data, 64'h0);
        @(negedge clk);
        wr_sel = 4'd15;
        #1;
        check("R7 after edge", rd_b_data, 64'hCAFE_0000_0000_0009);
        model[9] = 64'hCAFE_0000_0000_0009;

        // R5: a null write with all-ones data touches nothing
        @(negedge clk);
        wr_sel = 4'd15; wr_data = '1;
        @(negedge clk);
        sweep("R5 null write");

        // R6: the null read stays zero on both ports
        rd_a_sel = 4'd15; rd_b_sel = 4'd15;
        #1;
        check("R6 null read A", rd_a_data, 64'h0);
        check("R6 null read B", rd_b_data, 64'h0);

        // R1: a later reset clears contents even with a write pending
        @(negedge clk);
        rst_n = 1'b0; wr_sel = 4'd14; wr_data = 64'h7777;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 15; i++) model[i] = '0;
        sweep("R1 clear after use");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule